// File: doc/BRIEF.md
# Control Register Update Unit

This unit holds the paging and mode control registers of a 32-bit paged processor: the machine control word (CR0), the fault address register (CR2), the page-table base (CR3) and the extension control word (CR4). It also holds a 32-bit address gate mask whose bit 20 can be switched off to emulate address wrap-around. Software-visible state is changed through a single write port that takes one register write per cycle. A separate gate strobe changes the address mask.

Every CR0 write also refreshes a set of derived mode flags that the rest of the core consumes directly. These are the protected-mode flag, the forced segment-base-add flag and the three coprocessor control flags. The unit compares each incoming value with the stored one and decides whether the translation cache has to be flushed. It then issues a registered one-cycle flush request that is marked either full (global entries included) or non-global. A change of the address gate also issues a one-cycle execution-exit pulse, so that running code is unlinked.

The flush decision is held in a three-state machine. The states are ST_QUIET (no request), ST_LOCAL_FLUSH (non-global request) and ST_FULL_FLUSH (full request). On every clock edge, any state moves to ST_FULL_FLUSH when a full-flush cause is present. It moves to ST_LOCAL_FLUSH when only a non-global cause is present, and to ST_QUIET when there is no cause. Each state therefore lasts exactly one cycle unless a new cause arrives.

Top module: `cr_update_unit`

## Requirements
- R1: After reset, CR0 reads 0x60000010, CR2, CR3 and CR4 read 0, and the address mask is 0xFFFFFFFF. The flags read pe_mode=0, seg_add=1, fpu_mp=fpu_em=fpu_ts=0, and flush_req, flush_global and exit_req are all 0.
- R2: After any CR0 write, bit 4 of CR0 reads as 1 whatever value was written. All other bits read as written.
- R3: A CR0 write whose value differs from the stored one in bit 31, bit 16 or bit 0 gives flush_req=1 with flush_global=1 in the cycle after the write. A CR0 write that changes only other bits gives no flush.
- R4: A CR3 write always stores the value. It gives flush_req=1 with flush_global=0 in the next cycle only if stored CR0 bit 31 is 1. Otherwise it gives no flush.
- R5: A CR4 write whose value differs from the stored one in bit 4, 5 or 7 gives a full flush (flush_req=1, flush_global=1) in the next cycle. Changes to other bits give no flush.
- R6: After a CR0 write, pe_mode equals CR0 bit 0, and seg_add is 1 while pe_mode is 0 and 0 while pe_mode is 1.
- R7: After each CR0 write, fpu_mp, fpu_em and fpu_ts equal written bits 1, 2 and 3. Between CR0 writes they hold.
- R8: A gate strobe whose gate_val differs from mask bit 20 sets mask bit 20 to gate_val while all other mask bits stay 1. In the next cycle it raises flush_req=1, flush_global=1 and exit_req=1.
- R9: A gate strobe whose gate_val equals mask bit 20 leaves the mask unchanged and raises no flush and no exit pulse.
- R10: Flush and exit pulses last one cycle when no new cause follows. When a full cause and a non-global cause occur in the same cycle, the request is full (flush_global=1).
- R11: rd_data returns the selected register with no clock delay. wr_sel and rd_sel both use 0=CR0, 1=CR2, 2=CR3, 3=CR4.
- R12: A CR2 write stores the value and raises no flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target (0=CR0,1=CR2,2=CR3,3=CR4) |
| wr_data | input | 32 | Write value |
| gate_wr | input | 1 | Address gate update strobe |
| gate_val | input | 1 | New address gate state for bit 20 |
| rd_sel | input | 2 | Read select (same encoding as wr_sel) |
| rd_data | output | 32 | Selected register value |
| addr_mask | output | 32 | Address mask with gated bit 20 |
| pe_mode | output | 1 | Derived protected-mode flag |
| seg_add | output | 1 | Derived forced segment-add flag |
| fpu_mp | output | 1 | Derived coprocessor monitor flag |
| fpu_em | output | 1 | Derived coprocessor emulate flag |
| fpu_ts | output | 1 | Derived task-switched flag |
| flush_req | output | 1 | One-cycle translation flush request |
| flush_global | output | 1 | Qualifier: 1 = flush global entries too |
| exit_req | output | 1 | One-cycle execution-exit pulse |

## Verification
The embedded properties watch several rules on every cycle. The forced extension-type bit is checked after CR0 writes, and the CR0 translation-bit flush rule and the absence of a flush for CR3 writes with paging off are checked too. The properties also cover the segment-add flag staying high in real mode, the coprocessor flags holding between CR0 writes, and the mask keeping every bit but 20 set. They further check that a same-state gate strobe leaves the mask alone and that a full cause always wins over a non-global one. The directed scenarios alone show the exact reset values and read-back contents through the select port. Only they show the per-bit flush choices for CR4, the non-global flush once paging is on, and the combined CR3-plus-gate collision with its exit pulse.

// File: rtl/cru_pkg.sv
package cru_pkg;

    localparam int unsigned XW        = 32;
    localparam int unsigned SEL_W     = 2;
    localparam int unsigned NUM_SLOTS = 4;

    // register select encoding (write and read)
    localparam logic [SEL_W-1:0] SEL_CR0 = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CR2 = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CR3 = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CR4 = 2'd3;

    // CR0 bit positions
    localparam int unsigned PE_BIT = 0;
    localparam int unsigned MP_BIT = 1;
    localparam int unsigned EM_BIT = 2;
    localparam int unsigned TS_BIT = 3;
    localparam int unsigned ET_BIT = 4;
    localparam int unsigned WP_BIT = 16;
    localparam int unsigned PG_BIT = 31;

    // CR4 bit positions
    localparam int unsigned PSE_BIT = 4;
    localparam int unsigned PAE_BIT = 5;
    localparam int unsigned PGE_BIT = 7;

    localparam int unsigned GATE_BIT = 20;

    localparam logic [XW-1:0] CR0_RESET = 32'h6000_0010;
    localparam logic [XW-1:0] ET_FORCE  = XW'(1) << ET_BIT;
    localparam logic [XW-1:0] CR0_XLAT  = (XW'(1) << PG_BIT) | (XW'(1) << WP_BIT) | (XW'(1) << PE_BIT);
    localparam logic [XW-1:0] CR4_XLAT  = (XW'(1) << PSE_BIT) | (XW'(1) << PAE_BIT) | (XW'(1) << PGE_BIT);

    typedef enum logic [1:0] {
        ST_QUIET       = 2'd0,
        ST_LOCAL_FLUSH = 2'd1,
        ST_FULL_FLUSH  = 2'd2
    } flush_state_e;

endpackage

// File: rtl/cru_regfile.sv
module cru_regfile
    import cru_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [XW-1:0]                  wr_data,
    output logic [NUM_SLOTS-1:0][XW-1:0]   cr_q,
    output logic                           cr0_wr,
    output logic [3:0]                     cr0_low_new,
    output logic                           full_cause,
    output logic                           local_cause
);

    // slot order follows the select encoding: CR0, CR2, CR3, CR4
    function automatic logic [XW-1:0] slot_reset(input int unsigned idx);
        return (idx == 0) ? CR0_RESET : '0;
    endfunction

    function automatic logic [XW-1:0] slot_force(input int unsigned idx);
        return (idx == 0) ? ET_FORCE : '0;
    endfunction

    logic [NUM_SLOTS-1:0] slot_we;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [XW-1:0] slot_q;

        assign slot_we[g] = wr_en && (wr_sel == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= slot_reset(g);
            else if (slot_we[g])
                slot_q <= wr_data | slot_force(g);
        end

        assign cr_q[g] = slot_q;
    end

    logic [XW-1:0] cr0_next;
    logic          cr0_xlat_diff;
    logic          cr4_xlat_diff;

    always_comb begin
        cr0_next      = wr_data | ET_FORCE;
        cr0_xlat_diff = |((cr0_next ^ cr_q[0]) & CR0_XLAT);
        cr4_xlat_diff = |((wr_data ^ cr_q[3]) & CR4_XLAT);
        cr0_wr        = slot_we[0];
        cr0_low_new   = wr_data[3:0];
        full_cause    = (slot_we[0] && cr0_xlat_diff) || (slot_we[3] && cr4_xlat_diff);
        local_cause   = slot_we[2] && cr_q[0][PG_BIT];
    end

    // R2
    et_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CR0) |=> cr_q[0][ET_BIT]);

    // R12
    cr2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_CR2) |=> $stable(cr_q[1]));

endmodule

// File: rtl/cru_mode_flags.sv
module cru_mode_flags
    import cru_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cr0_wr,
    input  logic [3:0] cr0_low_new,
    output logic       pe_q,
    output logic       segadd_q,
    output logic       mp_q,
    output logic       em_q,
    output logic       ts_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_q     <= CR0_RESET[PE_BIT];
            segadd_q <= !CR0_RESET[PE_BIT];
            mp_q     <= CR0_RESET[MP_BIT];
            em_q     <= CR0_RESET[EM_BIT];
            ts_q     <= CR0_RESET[TS_BIT];
        end else if (cr0_wr) begin
            pe_q     <= cr0_low_new[PE_BIT];
            segadd_q <= !cr0_low_new[PE_BIT];
            mp_q     <= cr0_low_new[MP_BIT];
            em_q     <= cr0_low_new[EM_BIT];
            ts_q     <= cr0_low_new[TS_BIT];
        end
    end

    // R6
    segadd_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_q |-> segadd_q);

    // R7
    fpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cr0_wr |=> $stable({mp_q, em_q, ts_q}));

endmodule

// File: rtl/cru_gate_mask.sv
module cru_gate_mask
    import cru_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_wr,
    input  logic          gate_val,
    output logic [XW-1:0] mask_q,
    output logic          gate_change
);

    localparam logic [XW-1:0] GATE_HOLE = ~(XW'(1) << GATE_BIT);

    assign gate_change = gate_wr && (gate_val != mask_q[GATE_BIT]);

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (gate_change)
            mask_q <= GATE_HOLE | (XW'(gate_val) << GATE_BIT);
    end

    // R8
    other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q | ~GATE_HOLE) == '1);

    // R9
    same_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_wr && gate_val == mask_q[GATE_BIT]) |=> $stable(mask_q));

endmodule

// File: rtl/cru_flush_fsm.sv
module cru_flush_fsm
    import cru_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full_cause,
    input  logic local_cause,
    input  logic exit_cause,
    output logic flush_req,
    output logic flush_global,
    output logic exit_req
);

    flush_state_e state_q;
    flush_state_e state_d;
    logic         exit_q;

    always_comb begin
        if (full_cause)
            state_d = ST_FULL_FLUSH;
        else if (local_cause)
            state_d = ST_LOCAL_FLUSH;
        else
            state_d = ST_QUIET;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            exit_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            exit_q  <= exit_cause;
        end
    end

    always_comb begin
        flush_req    = 1'b0;
        flush_global = 1'b0;
        unique case (state_q)
            ST_QUIET: begin
                flush_req    = 1'b0;
                flush_global = 1'b0;
            end
            ST_LOCAL_FLUSH: begin
                flush_req    = 1'b1;
                flush_global = 1'b0;
            end
            ST_FULL_FLUSH: begin
                flush_req    = 1'b1;
                flush_global = 1'b1;
            end
            default: begin
                flush_req    = 1'b0;
                flush_global = 1'b0;
            end
        endcase
        exit_req = exit_q;
    end

    // R10
    global_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_global |-> flush_req);

    // R10
    full_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_cause && local_cause) |=> (flush_req && flush_global));

    // R10
    pulse_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_cause && !local_cause) |=> !flush_req);

endmodule

// File: rtl/cr_update_unit.sv
module cr_update_unit
    import cru_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        gate_wr,
    input  logic        gate_val,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic [31:0] addr_mask,
    output logic        pe_mode,
    output logic        seg_add,
    output logic        fpu_mp,
    output logic        fpu_em,
    output logic        fpu_ts,
    output logic        flush_req,
    output logic        flush_global,
    output logic        exit_req
);

    logic [NUM_SLOTS-1:0][XW-1:0] cr_w;
    logic                         cr0_wr_w;
    logic [3:0]                   cr0_low_w;
    logic                         reg_full_w;
    logic                         reg_local_w;
    logic                         gate_change_w;

    cru_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .cr_q        (cr_w),
        .cr0_wr      (cr0_wr_w),
        .cr0_low_new (cr0_low_w),
        .full_cause  (reg_full_w),
        .local_cause (reg_local_w)
    );

    cru_mode_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .cr0_wr      (cr0_wr_w),
        .cr0_low_new (cr0_low_w),
        .pe_q        (pe_mode),
        .segadd_q    (seg_add),
        .mp_q        (fpu_mp),
        .em_q        (fpu_em),
        .ts_q        (fpu_ts)
    );

    cru_gate_mask u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_wr     (gate_wr),
        .gate_val    (gate_val),
        .mask_q      (addr_mask),
        .gate_change (gate_change_w)
    );

    cru_flush_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .full_cause   (reg_full_w || gate_change_w),
        .local_cause  (reg_local_w),
        .exit_cause   (gate_change_w),
        .flush_req    (flush_req),
        .flush_global (flush_global),
        .exit_req     (exit_req)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_CR0: rd_data = cr_w[0];
            SEL_CR2: rd_data = cr_w[1];
            SEL_CR3: rd_data = cr_w[2];
            SEL_CR4: rd_data = cr_w[3];
            default: rd_data = '0;
        endcase
    end

    // R3
    cr0_xlat_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CR0 && ((wr_data ^ cr_w[0]) & CR0_XLAT) != '0)
        |=> (flush_req && flush_global));

    // R4
    cr3_nopg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CR3 && !cr_w[0][PG_BIT] && !gate_change_w)
        |=> !flush_req);

    // R8
    gate_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_wr && gate_val != addr_mask[GATE_BIT]) |=> (exit_req && flush_global));

endmodule

// File: tb/cr_update_unit_tb_top.sv
`timescale 1ns/1ps
module cr_update_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        gate_wr = 1'b0;
    logic        gate_val = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [31:0] addr_mask;
    logic        pe_mode, seg_add, fpu_mp, fpu_em, fpu_ts;
    logic        flush_req, flush_global, exit_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cr_update_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .gate_wr(gate_wr), .gate_val(gate_val), .rd_sel(rd_sel), .rd_data(rd_data),
        .addr_mask(addr_mask), .pe_mode(pe_mode), .seg_add(seg_add), .fpu_mp(fpu_mp),
        .fpu_em(fpu_em), .fpu_ts(fpu_ts), .flush_req(flush_req),
        .flush_global(flush_global), .exit_req(exit_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle of stimulus; returns at the falling edge after the capturing edge
    task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] d,
                        input logic gw, input logic gv);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; gate_wr = gw; gate_val = gv;
        @(negedge clk);
        wr_en = 1'b0; gate_wr = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [1:0] sel, input logic [31:0] exp);
        rd_sel = sel;
        #0.5;
        chk(tag, rd_data, exp);
    endtask

    task automatic pulse_chk(input string tag, input logic fr, input logic fg, input logic ex);
        chk({tag, " flush_req"}, {31'd0, flush_req}, {31'd0, fr});
        chk({tag, " flush_global"}, {31'd0, flush_global}, {31'd0, fg});
        chk({tag, " exit_req"}, {31'd0, exit_req}, {31'd0, ex});
    endtask

    task automatic t_reset();
        read_chk("R1 cr0", 2'd0, 32'h6000_0010);
        read_chk("R1 cr2", 2'd1, 32'h0);
        read_chk("R1 cr3", 2'd2, 32'h0);
        read_chk("R11 cr4", 2'd3, 32'h0);
        chk("R1 mask", addr_mask, 32'hFFFF_FFFF);
        chk("R1 flags", {27'd0, pe_mode, seg_add, fpu_mp, fpu_em, fpu_ts}, 32'b01000);
        pulse_chk("R1", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_cr0_plain();
        step(1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0);
        read_chk("R2 et forced", 2'd0, 32'h0000_0010);
        pulse_chk("R3 no xlat change", 1'b0, 1'b0, 1'b0);
        step(1'b1, 2'd0, 32'h0000_000E, 1'b0, 1'b0);
        read_chk("R2 cr0", 2'd0, 32'h0000_001E);
        chk("R7 fpu set", {29'd0, fpu_mp, fpu_em, fpu_ts}, 32'b111);
        pulse_chk("R3 fpu bits only", 1'b0, 1'b0, 1'b0);
        step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
        chk("R7 fpu hold", {29'd0, fpu_mp, fpu_em, fpu_ts}, 32'b111);
    endtask

    task automatic t_cr0_pe();
        step(1'b1, 2'd0, 32'h0000_0001, 1'b0, 1'b0);
        pulse_chk("R3 pe change", 1'b1, 1'b1, 1'b0);
        chk("R6 pe/segadd", {30'd0, pe_mode, seg_add}, 32'b10);
        chk("R7 fpu clear", {29'd0, fpu_mp, fpu_em, fpu_ts}, 32'b000);
        read_chk("R2 cr0 pe", 2'd0, 32'h0000_0011);
        @(negedge clk);
        pulse_chk("R10 single cycle", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_cr3();
        step(1'b1, 2'd2, 32'h1234_5000, 1'b0, 1'b0);
        pulse_chk("R4 paging off", 1'b0, 1'b0, 1'b0);
        read_chk("R4 cr3 stored", 2'd2, 32'h1234_5000);
        step(1'b1, 2'd0, 32'h8000_0001, 1'b0, 1'b0);
        pulse_chk("R3 pg change", 1'b1, 1'b1, 1'b0);
        step(1'b1, 2'd2, 32'hABCD_E000, 1'b0, 1'b0);
        pulse_chk("R4 paging on", 1'b1, 1'b0, 1'b0);
        read_chk("R4 cr3 stored 2", 2'd2, 32'hABCD_E000);
        step(1'b1, 2'd0, 32'h8001_0001, 1'b0, 1'b0);
        pulse_chk("R3 wp change", 1'b1, 1'b1, 1'b0);
        step(1'b1, 2'd0, 32'h8001_0021, 1'b0, 1'b0);
        pulse_chk("R3 non-xlat bit", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_cr4();
        step(1'b1, 2'd3, 32'h0000_0008, 1'b0, 1'b0);
        pulse_chk("R5 bit3 only", 1'b0, 1'b0, 1'b0);
        step(1'b1, 2'd3, 32'h0000_0018, 1'b0, 1'b0);
        pulse_chk("R5 pse", 1'b1, 1'b1, 1'b0);
        step(1'b1, 2'd3, 32'h0000_0038, 1'b0, 1'b0);
        pulse_chk("R5 pae", 1'b1, 1'b1, 1'b0);
        step(1'b1, 2'd3, 32'h0000_00B8, 1'b0, 1'b0);
        pulse_chk("R5 pge", 1'b1, 1'b1, 1'b0);
        step(1'b1, 2'd3, 32'h0000_00B8, 1'b0, 1'b0);
        pulse_chk("R5 same value", 1'b0, 1'b0, 1'b0);
        read_chk("R11 cr4", 2'd3, 32'h0000_00B8);
    endtask

    task automatic t_cr2();
        step(1'b1, 2'd1, 32'hDEAD_BEEF, 1'b0, 1'b0);
        pulse_chk("R12 no flush", 1'b0, 1'b0, 1'b0);
        read_chk("R12 cr2", 2'd1, 32'hDEAD_BEEF);
    endtask

    task automatic t_gate();
        step(1'b0, 2'd0, 32'h0, 1'b1, 1'b1);
        pulse_chk("R9 same gate", 1'b0, 1'b0, 1'b0);
        chk("R9 mask", addr_mask, 32'hFFFF_FFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0);
        pulse_chk("R8 gate off", 1'b1, 1'b1, 1'b1);
        chk("R8 mask off", addr_mask, 32'hFFEF_FFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0);
        pulse_chk("R9 same off", 1'b0, 1'b0, 1'b0);
        chk("R9 mask off", addr_mask, 32'hFFEF_FFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1, 1'b1);
        pulse_chk("R8 gate on", 1'b1, 1'b1, 1'b1);
        chk("R8 mask on", addr_mask, 32'hFFFF_FFFF);
    endtask

    task automatic t_collide();
        step(1'b1, 2'd2, 32'h0000_7000, 1'b1, 1'b0);
        pulse_chk("R10 full wins", 1'b1, 1'b1, 1'b1);
        chk("R10 mask", addr_mask, 32'hFFEF_FFFF);
        read_chk("R4 cr3 collide", 2'd2, 32'h0000_7000);
        @(negedge clk);
        pulse_chk("R10 ends", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cr0_plain();
        t_cr0_pe();
        t_cr3();
        t_cr4();
        t_cr2();
        t_gate();
        t_collide();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule